// File: doc/BRIEF.md
# Variable-Page Associative Address Translation Buffer

This block is a fully associative translation buffer that maps 32-bit virtual addresses to physical addresses. Every slot holds its own virtual page number, address-space identifier, physical page number and attribute bits. A two-bit size code per slot picks a page of 1 KB, 4 KB, 64 KB or 1 MB, so slots of different granularity live side by side and are all searched in parallel.

A lookup is started by a one-cycle request strobe carrying the address, the current address-space identifier, the privilege level and the single-virtual-space flag. One cycle later the block presents a response strobe with a status code (hit, miss or multi-hit), the index of the matching slot, the translated address and the slot's protection and dirty bits. Enforcing protection is left to the caller. Slots are loaded through a write port, and a write issued in the same cycle as a lookup only affects later lookups. A replacement counter advances on every lookup and folds back to zero at a programmable boundary, giving the refill logic a victim index.

Top module: `xlat_buffer`

## Requirements
- R1: A slot whose valid bit is 0 never matches, whatever its other fields hold.
- R2: Size code 0 compares virtual address bits 31:10, code 1 bits 31:12, code 2 bits 31:16 and code 3 bits 31:20 against the same bits of the stored page number (page numbers are held as address bits 31:10).
- R3: The identifier is compared only when the slot's shared bit is 0 and the request is either unprivileged or has the single-virtual-space flag clear; otherwise the page-number compare alone decides the match.
- R4: rsp_status is 0 (hit) when exactly one slot matches, 1 (miss) when none matches and 2 (multi-hit) when two or more match; the value 3 never appears. On a hit rsp_idx is the matching slot.
- R5: On a hit the translated address takes the stored physical page bits above the page boundary and the virtual address bits below it.
- R6: Each request moves the counter to (count+1) mod 64, or to 0 when that value equals the boundary input.
- R7: rsp_valid is 1 in exactly the cycle after a cycle with req_valid 1.
- R8: A slot written in the cycle of a lookup takes part only in lookups that start in later cycles.
- R9: After reset rsp_valid is 0, the counter is 0 and every slot is invalid.
- R10: On a miss or multi-hit, rsp_idx, rsp_pa, rsp_prot and rsp_dirty are all 0; on a hit rsp_prot and rsp_dirty carry the slot's stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load a slot this cycle |
| wr_idx | input | 6 | Slot to load |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_asid | input | 8 | Address-space identifier of the slot |
| wr_ppn | input | 22 | Physical page number (address bits 31:10) |
| wr_valid | input | 1 | Valid bit |
| wr_shared | input | 1 | Shared bit, skips the identifier compare |
| wr_size | input | 2 | Page size code |
| wr_prot | input | 2 | Protection bits, passed through |
| wr_dirty | input | 1 | Dirty bit, passed through |
| req_valid | input | 1 | Lookup strobe |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Current address-space identifier |
| req_priv | input | 1 | 1 for privileged mode |
| req_svm | input | 1 | Single-virtual-space flag |
| urc_bound | input | 6 | Boundary at which the counter folds to 0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 multi-hit |
| rsp_idx | output | 6 | Matching slot on a hit |
| rsp_pa | output | 32 | Translated address on a hit |
| rsp_prot | output | 2 | Protection bits of the matching slot |
| rsp_dirty | output | 1 | Dirty bit of the matching slot |
| urc | output | 6 | Replacement counter |

## Verification
On every cycle the assertions check the response timing against the request strobe, that the counter either holds or steps by one or folds to zero, that no match comes from an invalid slot, that non-hit responses carry zeroed fields, and that a hit keeps the offset bits of the requested address. Whether the page-size masks, the identifier bypass rule, the multi-hit count and the write-versus-lookup ordering give the right answer can only be shown by the bench's scenarios, where a behavioural model of the slots predicts each response and directed lookups straddle page edges, mix shared and private slots and overlap a large page with a small one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W   = 32;
    localparam int OFS_W  = 10;
    localparam int PN_W   = VA_W - OFS_W;
    localparam int ASID_W = 8;

    typedef enum logic [1:0] {
        ST_HIT   = 2'd0,
        ST_MISS  = 2'd1,
        ST_MULTI = 2'd2
    } xlat_status_e;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic [1:0]        size;
        logic [1:0]        prot;
        logic              dirty;
        logic [ASID_W-1:0] asid;
        logic [PN_W-1:0]   vpn;
        logic [PN_W-1:0]   ppn;
    } slot_t;

    // Mask over page-number bits: 1 marks a bit that is compared / taken from the slot.
    function automatic logic [PN_W-1:0] page_mask(input logic [1:0] sz);
        logic [PN_W-1:0] m;
        case (sz)
            2'd0:    m = {PN_W{1'b1}};
            2'd1:    m = {{(PN_W-2){1'b1}}, 2'b0};
            2'd2:    m = {{(PN_W-6){1'b1}}, 6'b0};
            default: m = {{(PN_W-10){1'b1}}, 10'b0};
        endcase
        return m;
    endfunction

    function automatic logic slot_hits(input slot_t s,
                                       input logic [PN_W-1:0] pn,
                                       input logic [ASID_W-1:0] asid,
                                       input logic priv,
                                       input logic svm);
        logic [PN_W-1:0] m;
        logic id_ok;
        m     = page_mask(s.size);
        id_ok = s.shared || (priv && svm) || (s.asid == asid);
        return s.valid && id_ok && ((s.vpn & m) == (pn & m));
    endfunction

endpackage

// File: rtl/xlat_slot_store.sv
module xlat_slot_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  slot_t             wr_slot,
    input  logic [PN_W-1:0]   look_pn,
    input  logic [ASID_W-1:0] look_asid,
    input  logic              look_priv,
    input  logic              look_svm,
    output logic [ENTRIES-1:0] match,
    output slot_t             slots [ENTRIES]
);

    slot_t slots_d [ENTRIES];
    slot_t slots_q [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            slots_d[i] = slots_q[i];
        end
        if (wr_en) begin
            slots_d[wr_idx] = wr_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                slots_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                slots_q[i] <= slots_d[i];
            end
        end
    end

    // One compare cell per slot, all searched in parallel on the stored state.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        assign match[g]     = slot_hits(slots_q[g], look_pn, look_asid, look_priv, look_svm);
        assign valid_vec[g] = slots_q[g].valid;
        assign slots[g]     = slots_q[g];
    end

    // R1
    invalid_slot_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match & ~valid_vec) == '0);

    // R1
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_vec));

endmodule

// File: rtl/xlat_resolve.sv
module xlat_resolve
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match,
    input  slot_t              slots [ENTRIES],
    input  logic [VA_W-1:0]    va,
    output xlat_status_e       status,
    output logic [IDX_W-1:0]   idx,
    output logic [VA_W-1:0]    pa,
    output logic [1:0]         prot,
    output logic               dirty
);

    logic [1:0]       hits;
    logic [IDX_W-1:0] sel;
    logic [PN_W-1:0]  m;
    slot_t            pick;

    always_comb begin
        hits = 2'd0;
        sel  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                if (hits != 2'd2) begin
                    hits = hits + 2'd1;
                end
                sel = IDX_W'(i);
            end
        end

        pick = slots[sel];
        m    = page_mask(pick.size);

        status = ST_MISS;
        idx    = '0;
        pa     = '0;
        prot   = '0;
        dirty  = 1'b0;
        if (hits == 2'd1) begin
            status = ST_HIT;
            idx    = sel;
            pa     = {(pick.ppn & m) | (va[VA_W-1:OFS_W] & ~m), va[OFS_W-1:0]};
            prot   = pick.prot;
            dirty  = pick.dirty;
        end else if (hits == 2'd2) begin
            status = ST_MULTI;
        end
    end

endmodule

// File: rtl/xlat_repl_ctr.sv
module xlat_repl_ctr #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [WIDTH-1:0] bound,
    output logic [WIDTH-1:0] count
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [WIDTH-1:0] inc;

    always_comb begin
        ctr_d = ctr_q;
        inc   = ctr_q.cnt + WIDTH'(1);
        if (step) begin
            ctr_d.cnt = (inc == bound) ? '0 : inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign count = ctr_q.cnt;

    // R6
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));

    // R6
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == '0) || (count == $past(count) + WIDTH'(1)));

    // R6
    ctr_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (count + WIDTH'(1) == bound)) |=> count == '0);

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PN_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PN_W-1:0]   wr_ppn,
    input  logic              wr_valid,
    input  logic              wr_shared,
    input  logic [1:0]        wr_size,
    input  logic [1:0]        wr_prot,
    input  logic              wr_dirty,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_priv,
    input  logic              req_svm,
    input  logic [IDX_W-1:0]  urc_bound,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [VA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_prot,
    output logic              rsp_dirty,
    output logic [IDX_W-1:0]  urc
);

    typedef struct packed {
        logic             valid;
        logic [1:0]       status;
        logic [IDX_W-1:0] idx;
        logic [VA_W-1:0]  pa;
        logic [1:0]       prot;
        logic             dirty;
    } resp_t;

    slot_t              wr_slot;
    logic [ENTRIES-1:0] match;
    slot_t              slots [ENTRIES];
    xlat_status_e       res_status;
    logic [IDX_W-1:0]   res_idx;
    logic [VA_W-1:0]    res_pa;
    logic [1:0]         res_prot;
    logic               res_dirty;
    resp_t              rsp_d, rsp_q;

    always_comb begin
        wr_slot        = '0;
        wr_slot.valid  = wr_valid;
        wr_slot.shared = wr_shared;
        wr_slot.size   = wr_size;
        wr_slot.prot   = wr_prot;
        wr_slot.dirty  = wr_dirty;
        wr_slot.asid   = wr_asid;
        wr_slot.vpn    = wr_vpn;
        wr_slot.ppn    = wr_ppn;
    end

    xlat_slot_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_slot   (wr_slot),
        .look_pn   (req_va[VA_W-1:OFS_W]),
        .look_asid (req_asid),
        .look_priv (req_priv),
        .look_svm  (req_svm),
        .match     (match),
        .slots     (slots)
    );

    xlat_resolve #(.ENTRIES(ENTRIES)) u_resolve (
        .match  (match),
        .slots  (slots),
        .va     (req_va),
        .status (res_status),
        .idx    (res_idx),
        .pa     (res_pa),
        .prot   (res_prot),
        .dirty  (res_dirty)
    );

    xlat_repl_ctr #(.WIDTH(IDX_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (req_valid),
        .bound (urc_bound),
        .count (urc)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.status = res_status;
            rsp_d.idx    = res_idx;
            rsp_d.pa     = res_pa;
            rsp_d.prot   = res_prot;
            rsp_d.dirty  = res_dirty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q        <= '0;
            rsp_q.status <= ST_MISS;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_status = rsp_q.status;
    assign rsp_idx    = rsp_q.idx;
    assign rsp_pa     = rsp_q.pa;
    assign rsp_prot   = rsp_q.prot;
    assign rsp_dirty  = rsp_q.dirty;

    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status != 2'd3);

    // R10
    nonhit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != ST_HIT) |->
            (rsp_idx == '0 && rsp_pa == '0 && rsp_prot == '0 && !rsp_dirty));

    // R5
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && res_status == ST_HIT) |=>
            rsp_pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0]));

endmodule

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [21:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [21:0] wr_ppn = '0;
    logic        wr_valid = 1'b0;
    logic        wr_shared = 1'b0;
    logic [1:0]  wr_size = '0;
    logic [1:0]  wr_prot = '0;
    logic        wr_dirty = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_asid = '0;
    logic        req_priv = 1'b0;
    logic        req_svm = 1'b0;
    logic [5:0]  urc_bound = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [5:0]  rsp_idx;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_prot;
    logic        rsp_dirty;
    logic [5:0]  urc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlat_buffer dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_ppn(wr_ppn), .wr_valid(wr_valid), .wr_shared(wr_shared),
        .wr_size(wr_size), .wr_prot(wr_prot), .wr_dirty(wr_dirty),
        .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid),
        .req_priv(req_priv), .req_svm(req_svm), .urc_bound(urc_bound),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_idx(rsp_idx),
        .rsp_pa(rsp_pa), .rsp_prot(rsp_prot), .rsp_dirty(rsp_dirty), .urc(urc)
    );

    // Behavioural model of the slots
    bit          m_valid [N];
    bit          m_shared[N];
    int          m_size  [N];
    int          m_prot  [N];
    bit          m_dirty [N];
    int          m_asid  [N];
    logic [21:0] m_vpn   [N];
    logic [21:0] m_ppn   [N];

    bit          exp_valid = 0;
    int          exp_status = 1;
    int          exp_idx = 0;
    logic [31:0] exp_pa = '0;
    int          exp_prot = 0;
    bit          exp_dirty = 0;
    int          exp_urc = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_lookup(input logic [31:0] va, input int asid, input bit priv, input bit svm);
        int cnt;
        int sel;
        int low_bits;
        logic [31:0] lowm;
        cnt = 0;
        sel = 0;
        for (int i = 0; i < N; i++) begin
            if (!m_valid[i]) continue;
            case (m_size[i])
                0: low_bits = 10;
                1: low_bits = 12;
                2: low_bits = 16;
                default: low_bits = 20;
            endcase
            lowm = (32'd1 << low_bits) - 32'd1;
            if ((({m_vpn[i], 10'b0}) & ~lowm) == (va & ~lowm)) begin
                if (m_shared[i] || (priv && svm) || (m_asid[i] == asid)) begin
                    cnt++;
                    sel = i;
                end
            end
        end
        exp_idx = 0; exp_pa = '0; exp_prot = 0; exp_dirty = 0;
        if (cnt == 0) exp_status = 1;
        else if (cnt > 1) exp_status = 2;
        else begin
            exp_status = 0;
            exp_idx = sel;
            case (m_size[sel])
                0: low_bits = 10;
                1: low_bits = 12;
                2: low_bits = 16;
                default: low_bits = 20;
            endcase
            lowm = (32'd1 << low_bits) - 32'd1;
            exp_pa = ({m_ppn[sel], 10'b0} & ~lowm) | (va & lowm);
            exp_prot = m_prot[sel];
            exp_dirty = m_dirty[sel];
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
            exp_valid = 0;
            exp_urc = 0;
        end else begin
            int t;
            exp_valid = req_valid;
            if (req_valid) begin
                model_lookup(req_va, req_asid, req_priv, req_svm);
                t = (exp_urc + 1) % 64;
                exp_urc = (t == urc_bound) ? 0 : t;
            end
            if (wr_en) begin
                m_valid[wr_idx]  = wr_valid;
                m_shared[wr_idx] = wr_shared;
                m_size[wr_idx]   = wr_size;
                m_prot[wr_idx]   = wr_prot;
                m_dirty[wr_idx]  = wr_dirty;
                m_asid[wr_idx]   = wr_asid;
                m_vpn[wr_idx]    = wr_vpn;
                m_ppn[wr_idx]    = wr_ppn;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7", "rsp_valid", rsp_valid, exp_valid);
            if (exp_valid) begin
                chk("R4", "status", rsp_status, exp_status);
                chk("R4", "idx", rsp_idx, exp_idx);
                chk("R5", "pa", rsp_pa, exp_pa);
                chk("R10", "prot", rsp_prot, exp_prot);
                chk("R10", "dirty", rsp_dirty, exp_dirty);
            end
            chk("R6", "urc", urc, exp_urc);
        end
    end

    task automatic set_write(input int idx, input logic [31:0] va_base, input logic [31:0] pa_base,
                             input int asid, input bit valid, input bit shared, input int size,
                             input int prot, input bit dirty);
        wr_en = 1'b1; wr_idx = 6'(idx);
        wr_vpn = va_base[31:10]; wr_ppn = pa_base[31:10];
        wr_asid = 8'(asid); wr_valid = valid; wr_shared = shared;
        wr_size = 2'(size); wr_prot = 2'(prot); wr_dirty = dirty;
    endtask

    task automatic write_slot(input int idx, input logic [31:0] va_base, input logic [31:0] pa_base,
                              input int asid, input bit valid, input bit shared, input int size,
                              input int prot, input bit dirty);
        @(negedge clk);
        set_write(idx, va_base, pa_base, asid, valid, shared, size, prot, dirty);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input string tag, input logic [31:0] va, input int asid, input bit priv,
                          input bit svm, input int st, input int idx, input logic [31:0] pa);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_asid = 8'(asid); req_priv = priv; req_svm = svm;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "status", rsp_status, st);
        if (st == 0) begin
            chk(tag, "idx", rsp_idx, idx);
            chk(tag, "pa", rsp_pa, pa);
        end
    endtask

    initial begin : watchdog
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9", "rsp_valid", rsp_valid, 0);
        chk("R9", "urc", urc, 0);
        lookup("R9", 32'h0000_1000, 0, 0, 0, 1, 0, 0);

        write_slot(0, 32'h1234_5400, 32'h0ABC_D000, 1, 1, 0, 0, 3, 1);
        write_slot(1, 32'h2000_3000, 32'h3000_5000, 1, 1, 0, 1, 2, 0);
        write_slot(2, 32'h4007_8C00, 32'h5009_F400, 1, 1, 0, 2, 1, 1);
        write_slot(3, 32'h7FF0_0000, 32'h0120_0000, 9, 1, 1, 3, 0, 0);
        write_slot(5, 32'h6000_0000, 32'h0100_0000, 1, 0, 0, 3, 3, 1);

        // R2 and R5: each page size, inside and just past the page
        lookup("R2", 32'h1234_5678, 1, 0, 0, 0, 0, 32'h0ABC_D278);
        lookup("R2", 32'h1234_5A00, 1, 0, 0, 1, 0, 0);
        lookup("R2", 32'h2000_3FFC, 1, 0, 0, 0, 1, 32'h3000_5FFC);
        lookup("R2", 32'h2000_4000, 1, 0, 0, 1, 0, 0);
        lookup("R5", 32'h4007_ABCD, 1, 0, 0, 0, 2, 32'h5009_ABCD);
        lookup("R5", 32'h7FF1_2345, 3, 0, 0, 0, 3, 32'h0121_2345);

        // R3: identifier bypass rule
        lookup("R3", 32'h1234_5678, 2, 0, 0, 1, 0, 0);
        lookup("R3", 32'h1234_5678, 2, 1, 1, 0, 0, 32'h0ABC_D278);
        lookup("R3", 32'h1234_5678, 2, 1, 0, 1, 0, 0);
        lookup("R3", 32'h1234_5678, 2, 0, 1, 1, 0, 0);

        // R1: invalid slot with a matching page
        lookup("R1", 32'h6000_0010, 1, 0, 0, 1, 0, 0);

        // R4: overlapping large page gives multi-hit, removing it restores the hit
        write_slot(6, 32'h1230_0000, 32'h0F00_0000, 1, 1, 0, 3, 3, 0);
        lookup("R4", 32'h1234_5678, 1, 0, 0, 2, 0, 0);
        chk("R10", "multi idx", rsp_idx, 0);
        chk("R10", "multi pa", rsp_pa, 0);
        write_slot(6, 32'h1230_0000, 32'h0F00_0000, 1, 0, 0, 3, 3, 0);
        lookup("R4", 32'h1234_5678, 1, 0, 0, 0, 0, 32'h0ABC_D278);
        chk("R10", "hit prot", rsp_prot, 3);
        chk("R10", "hit dirty", rsp_dirty, 1);

        // R8: write and lookup in the same cycle
        @(negedge clk);
        set_write(7, 32'h8880_0000, 32'h0C00_0000, 1, 1, 0, 3, 2, 0);
        req_valid = 1'b1; req_va = 32'h8880_0040; req_asid = 8'd1; req_priv = 1'b0; req_svm = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R8", "same-cycle status", rsp_status, 1);
        lookup("R8", 32'h8880_0040, 1, 0, 0, 0, 7, 32'h0C00_0040);

        // R6: counter folding at a small boundary
        urc_bound = 6'd3;
        for (int k = 0; k < 70; k++) begin
            lookup("R6", 32'h2000_3000, 1, 0, 0, 0, 1, 32'h3000_5000);
            if (k >= 65) chk("R6", "urc below bound", (urc < 6'd3), 1);
        end

        // R7: idle cycles give no response
        repeat (3) @(negedge clk);
        chk("R7", "idle rsp_valid", rsp_valid, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule